// File: doc/BRIEF.md
# Four-Channel Compare-Match PWM Timer

This block holds four independent 16-bit counting channels behind a simple 16-bit register bus with byte addresses. Every channel has its own counter, a divide-by-4^k prescaler, a choice of counting edge on the prescaled clock, a selectable clear source and four compare registers. A match on a compare register sets a sticky status flag. A match can also restart the counter and drive the channel's output pin. One shared register starts and stops the channels.

Pulse-width modulation works like this. The pin takes a programmed start level each time the counter restarts. On a compare A match the pin takes the programmed action. Compare B, used as the clear source, sets the period. Software can also park the pin at a fixed level by choosing the no-action setting. It can change the duty on a running channel by rewriting compare A, and the counter keeps going.

Top module: `pwm_match_timer`

## Requirements
- R1: Bit n of the start register at byte address 0x00 lets channel n count. While that bit is 0 the channel's counter holds its value.
- R2: Channel n's registers sit at 0x10 + n*0x40 plus an offset: control 0x00 (8 bits), mode 0x04 (2 bits), pin control 0x08 (3 bits), interrupt enable 0x0C (4 bits), status 0x10, counter 0x14, compare A/B/C/D at 0x18/0x1C/0x20/0x24 (16 bits). Unused bits read 0. Addresses outside every register read 0 and ignore writes.
- R3: Control bits [1:0] = k divide the input clock by 4^k. Over any 64 consecutive enabled cycles the counter advances 64, 16, 4 or 1 times for k = 0..3 with a single edge selected.
- R4: Control bits [4:3] pick the counting edge of the prescaled clock: 0 rising, 1 falling, 2 or 3 both. Both edges doubles the count rate when k > 0. At k = 0 the counter advances once per cycle for any edge setting.
- R5: Control bits [7:5] pick the clear source: 1 compare A, 2 compare B, 5 compare C, 6 compare D. On a counting tick that finds the counter equal to that compare, the counter goes to 0 instead of incrementing. Any other code never clears, and the counter wraps from 0xFFFF to 0.
- R6: With mode = 2 (PWM) and clear on compare B, the pin equals the start level (pin control bit 2) while the counter is 0..A. It shows the action level while the counter is A+1..B. The period is B+1 ticks.
- R7: Pin control bits [1:0] give the compare A action: 1 drives 0, 2 drives 1, 3 toggles. A write to pin control loads the pin with the new bit 2. In mode 0 a restart does not reload the pin.
- R8: With pin control bits [1:0] = 0 the pin stays at bit 2, whatever the counter does.
- R9: Rewriting compare A on a running channel neither stops nor clears the counter, and the new duty governs the pin at once.
- R10: Status bits 0..3 are set by matches on compares A..D during a counting tick and stay set. Writing 0 to a bit clears it. Writing 1 leaves it unchanged.
- R11: A channel's interrupt output is high exactly when some status bit and its interrupt-enable bit (same position) are both 1.
- R12: After reset all registers and counters read 0, and all pins and interrupt outputs are low.
- R13: A write to the counter address loads the counter. It takes priority over a counting tick in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | ADDR_W (8) | Byte address of the register access |
| busWData | input | 16 | Write data |
| busWe | input | 1 | Write strobe, one register write per cycle |
| busRData | output | 16 | Read data of the addressed register, combinational |
| pwmOut | output | NUM_CH (4) | Output pin level per channel |
| irqOut | output | NUM_CH (4) | Masked status interrupt per channel |

## Verification
The bench builds the timer with its defaults: four channels and an 8-bit address. With these, all four register windows up to offset 0xF4 can be reached, and the shared start register holds one bit per channel. The six-bit prescale counter repeats every 64 cycles. Any 64-cycle run of an enabled channel therefore gives an exact tick count for every divide and edge setting, whatever the prescaler phase at start. Channels run with small compare values, so a restart, a toggle or a sticky flag appears within a few dozen cycles.

// File: rtl/pwmt_pkg.sv
package pwmt_pkg;
  localparam int CNT_W   = 16;  // counter, compare and bus data width
  localparam int NUM_CMP = 4;   // compare registers A..D per channel
  localparam int PSC_W   = 6;   // free-running divider covers 4**3
  localparam int CTRL_W  = 8;

  // clear-source codes decoded from control bits [7:5]
  localparam logic [2:0] CLR_A = 3'd1;
  localparam logic [2:0] CLR_B = 3'd2;
  localparam logic [2:0] CLR_C = 3'd5;
  localparam logic [2:0] CLR_D = 3'd6;

  localparam logic [1:0] MODE_PWM = 2'd2;
  localparam logic [1:0] ACT_NONE = 2'd0;
  localparam logic [1:0] ACT_LOW  = 2'd1;
  localparam logic [1:0] ACT_HIGH = 2'd2;

  // strobes from control to one channel datapath
  typedef struct packed {
    logic tick;   // counting tick this cycle
    logic cntWr;  // bus load of the counter
    logic stsWr;  // bus write-zero-to-clear of status
    logic iocWr;  // bus write of pin control
  } chStb_t;

  typedef struct packed {
    logic [2:0]                      clrSel;
    logic                            pwmMode;
    logic                            ioInit;
    logic [1:0]                      ioAct;
    logic [NUM_CMP-1:0]              ien;
    logic [NUM_CMP-1:0][CNT_W-1:0]   cmp;
  } chCfg_t;
endpackage

// File: rtl/pwmt_ctrl.sv
module pwmt_ctrl
  import pwmt_pkg::*;
#(
  parameter int NUM_CH   = 4,
  parameter int ADDR_W   = 8,
  parameter int WIN_BASE = 'h10,
  parameter int WIN_LG   = 6
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic [ADDR_W-1:0]               busAddr,
  input  logic [CNT_W-1:0]                busWData,
  input  logic                            busWe,
  output logic [CNT_W-1:0]                busRData,
  input  logic [NUM_CH-1:0][CNT_W-1:0]    cntIn,
  input  logic [NUM_CH-1:0][NUM_CMP-1:0]  stsIn,
  output chStb_t [NUM_CH-1:0]             stbOut,
  output chCfg_t [NUM_CH-1:0]             cfgOut
);
  localparam int OFF_W = WIN_LG;
  localparam logic [OFF_W-1:0] OFF_CTRL = OFF_W'('h00);
  localparam logic [OFF_W-1:0] OFF_MODE = OFF_W'('h04);
  localparam logic [OFF_W-1:0] OFF_IOC  = OFF_W'('h08);
  localparam logic [OFF_W-1:0] OFF_IEN  = OFF_W'('h0C);
  localparam logic [OFF_W-1:0] OFF_STS  = OFF_W'('h10);
  localparam logic [OFF_W-1:0] OFF_CNT  = OFF_W'('h14);
  localparam int               OFF_CMP0 = 'h18;

  logic [NUM_CH-1:0][CTRL_W-1:0]          ctrlR;
  logic [NUM_CH-1:0][1:0]                 modeR;
  logic [NUM_CH-1:0][2:0]                 iocR;
  logic [NUM_CH-1:0][NUM_CMP-1:0]         ienR;
  logic [NUM_CH-1:0][NUM_CMP-1:0][CNT_W-1:0] cmpR;
  logic [NUM_CH-1:0]                      startR;
  logic [PSC_W-1:0]                       divR;

  logic [ADDR_W-1:0] rel, chIdx;
  logic [OFF_W-1:0]  off;
  logic              inWin, startHit;

  assign rel      = busAddr - ADDR_W'(WIN_BASE);
  assign chIdx    = rel >> WIN_LG;
  assign off      = rel[OFF_W-1:0];
  assign inWin    = (busAddr >= ADDR_W'(WIN_BASE)) && (chIdx < ADDR_W'(NUM_CH));
  assign startHit = (busAddr == '0);

  function automatic logic tickFor(input logic [PSC_W-1:0] div,
                                   input logic [1:0] psc, input logic [1:0] edg);
    logic [PSC_W-1:0] mask;
    logic rise, fall;
    mask = PSC_W'((32'd1 << (2 * psc)) - 32'd1);
    rise = (div & mask) == (mask ^ (mask >> 1));
    fall = (div & mask) == '0;
    if (psc == 2'd0) return 1'b1;
    case (edg)
      2'd0:    return rise;
      2'd1:    return fall;
      default: return rise | fall;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlR <= '0; modeR <= '0; iocR <= '0; ienR <= '0;
      cmpR <= '0; startR <= '0; divR <= '0;
    end else begin
      divR <= divR + 1'b1;
      if (busWe && startHit) startR <= busWData[NUM_CH-1:0];
      for (int c = 0; c < NUM_CH; c++) begin
        if (busWe && inWin && chIdx == ADDR_W'(c)) begin
          case (off)
            OFF_CTRL: ctrlR[c] <= busWData[CTRL_W-1:0];
            OFF_MODE: modeR[c] <= busWData[1:0];
            OFF_IOC:  iocR[c]  <= busWData[2:0];
            OFF_IEN:  ienR[c]  <= busWData[NUM_CMP-1:0];
            default: ;
          endcase
          for (int i = 0; i < NUM_CMP; i++)
            if (off == OFF_W'(OFF_CMP0 + 4 * i)) cmpR[c][i] <= busWData;
        end
      end
    end
  end

  always_comb begin
    for (int c = 0; c < NUM_CH; c++) begin
      stbOut[c].tick  = startR[c] && tickFor(divR, ctrlR[c][1:0], ctrlR[c][4:3]);
      stbOut[c].cntWr = busWe && inWin && chIdx == ADDR_W'(c) && off == OFF_CNT;
      stbOut[c].stsWr = busWe && inWin && chIdx == ADDR_W'(c) && off == OFF_STS;
      stbOut[c].iocWr = busWe && inWin && chIdx == ADDR_W'(c) && off == OFF_IOC;
      cfgOut[c].clrSel  = ctrlR[c][7:5];
      cfgOut[c].pwmMode = (modeR[c] == MODE_PWM);
      cfgOut[c].ioInit  = iocR[c][2];
      cfgOut[c].ioAct   = iocR[c][1:0];
      cfgOut[c].ien     = ienR[c];
      cfgOut[c].cmp     = cmpR[c];
    end
  end

  always_comb begin
    busRData = '0;
    if (startHit) busRData = CNT_W'(startR);
    else if (inWin) begin
      for (int c = 0; c < NUM_CH; c++) begin
        if (chIdx == ADDR_W'(c)) begin
          case (off)
            OFF_CTRL: busRData = CNT_W'(ctrlR[c]);
            OFF_MODE: busRData = CNT_W'(modeR[c]);
            OFF_IOC:  busRData = CNT_W'(iocR[c]);
            OFF_IEN:  busRData = CNT_W'(ienR[c]);
            OFF_STS:  busRData = CNT_W'(stsIn[c]);
            OFF_CNT:  busRData = cntIn[c];
            default: ;
          endcase
          for (int i = 0; i < NUM_CMP; i++)
            if (off == OFF_W'(OFF_CMP0 + 4 * i)) busRData = cmpR[c][i];
        end
      end
    end
  end

  // with a divide of 4 or more, two ticks never fall on adjacent cycles (R3)
  for (genvar c = 0; c < NUM_CH; c++) begin : g_gap
    p_tick_gap_r3: assert property (@(posedge clk) disable iff (!rstN)
      (stbOut[c].tick && ctrlR[c][1:0] != 2'd0 && !busWe) |=> !stbOut[c].tick);
  end
endmodule

// File: rtl/pwmt_chan.sv
module pwmt_chan
  import pwmt_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  chStb_t             stb,
  input  chCfg_t             cfg,
  input  logic [CNT_W-1:0]   wData,
  output logic [CNT_W-1:0]   cnt,
  output logic [NUM_CMP-1:0] sts,
  output logic               pinOut,
  output logic               irq
);
  localparam int IO_INIT_BIT = 2;

  logic [NUM_CMP-1:0] match;
  logic               clrHit;

  for (genvar i = 0; i < NUM_CMP; i++) begin : g_match
    assign match[i] = stb.tick && (cnt == cfg.cmp[i]);
  end

  always_comb begin
    case (cfg.clrSel)
      CLR_A:   clrHit = match[0];
      CLR_B:   clrHit = match[1];
      CLR_C:   clrHit = match[2];
      CLR_D:   clrHit = match[3];
      default: clrHit = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt    <= '0;
      sts    <= '0;
      pinOut <= 1'b0;
    end else begin
      if (stb.cntWr)      cnt <= wData;
      else if (stb.tick)  cnt <= clrHit ? '0 : cnt + 1'b1;

      if (stb.stsWr) sts <= (sts & wData[NUM_CMP-1:0]) | match;
      else           sts <= sts | match;

      if (stb.iocWr)                       pinOut <= wData[IO_INIT_BIT];
      else if (cfg.ioAct == ACT_NONE)      pinOut <= cfg.ioInit;
      else if (cfg.pwmMode && clrHit)      pinOut <= cfg.ioInit;
      else if (match[0]) begin
        case (cfg.ioAct)
          ACT_LOW:  pinOut <= 1'b0;
          ACT_HIGH: pinOut <= 1'b1;
          default:  pinOut <= ~pinOut;
        endcase
      end
    end
  end

  assign irq = |(sts & cfg.ien);

  p_clear_to_zero_r5: assert property (@(posedge clk) disable iff (!rstN)
    (clrHit && !stb.cntWr) |=> cnt == '0);
  p_hold_when_idle_r1: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.tick && !stb.cntWr) |=> $stable(cnt));
  p_static_pin_r8: assert property (@(posedge clk) disable iff (!rstN)
    (cfg.ioAct == ACT_NONE && !stb.iocWr) |=> pinOut == $past(cfg.ioInit));
  p_restart_level_r6: assert property (@(posedge clk) disable iff (!rstN)
    (cfg.pwmMode && clrHit && !stb.iocWr) |=> pinOut == $past(cfg.ioInit));
  p_sticky_status_r10: assert property (@(posedge clk) disable iff (!rstN)
    !stb.stsWr |=> ($past(sts) & ~sts) == '0);
endmodule

// File: rtl/pwm_match_timer.sv
module pwm_match_timer
  import pwmt_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [CNT_W-1:0]  busWData,
  input  logic              busWe,
  output logic [CNT_W-1:0]  busRData,
  output logic [NUM_CH-1:0] pwmOut,
  output logic [NUM_CH-1:0] irqOut
);
  chStb_t [NUM_CH-1:0]            stb;
  chCfg_t [NUM_CH-1:0]            cfg;
  logic [NUM_CH-1:0][CNT_W-1:0]   cnt;
  logic [NUM_CH-1:0][NUM_CMP-1:0] sts;

  pwmt_ctrl #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) uCtrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWData(busWData),
    .busWe(busWe), .busRData(busRData), .cntIn(cnt), .stsIn(sts),
    .stbOut(stb), .cfgOut(cfg)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    pwmt_chan uChan (
      .clk(clk), .rstN(rstN), .stb(stb[c]), .cfg(cfg[c]), .wData(busWData),
      .cnt(cnt[c]), .sts(sts[c]), .pinOut(pwmOut[c]), .irq(irqOut[c])
    );
  end
endmodule

// File: tb/pwm_match_timer_test.sv
module pwm_match_timer_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [15:0] busWData = '0;
  logic        busWe = 1'b0;
  logic [15:0] busRData;
  logic [3:0]  pwmOut, irqOut;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  pwm_match_timer uut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWData(busWData),
    .busWe(busWe), .busRData(busRData), .pwmOut(pwmOut), .irqOut(irqOut)
  );

  typedef struct packed { logic [7:0] addr; logic [15:0] wdat; logic [15:0] expv; } vec_t;
  localparam int NVEC = 10;
  localparam vec_t VEC [NVEC] = '{
    '{8'h10, 16'hFFFF, 16'h00FF},  // ch0 control
    '{8'h14, 16'hFFFF, 16'h0003},  // ch0 mode
    '{8'h58, 16'hFFFF, 16'h0007},  // ch1 pin control
    '{8'h9C, 16'hFFFF, 16'h000F},  // ch2 interrupt enable
    '{8'hE8, 16'hA5C3, 16'hA5C3},  // ch3 compare A
    '{8'h6C, 16'h1234, 16'h1234},  // ch1 compare B
    '{8'hB0, 16'hBEEF, 16'hBEEF},  // ch2 compare C
    '{8'h34, 16'h0F0F, 16'h0F0F},  // ch0 compare D
    '{8'h24, 16'h4321, 16'h4321},  // ch0 counter
    '{8'h04, 16'hFFFF, 16'h0000}   // unmapped
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    busAddr = a; busWData = d; busWe = 1'b1;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [15:0] d);
    busAddr = a;
    #1;
    d = busRData;
  endtask

  // runs ch0 for m enabled edges from startVal, returns the counter
  task automatic runCount(input logic [15:0] ctl, input logic [15:0] startVal,
                          input int m, output logic [15:0] res);
    wr(8'h10, ctl);
    wr(8'h24, startVal);
    wr(8'h00, 16'h0001);
    repeat (m - 1) @(negedge clk);
    wr(8'h00, 16'h0000);
    rd(8'h24, res);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] v, c0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R12 reset state
    rd(8'h00, v); chk("R12 start", v, 0);
    rd(8'h10, v); chk("R12 ctrl0", v, 0);
    rd(8'hE4, v); chk("R12 cnt3", v, 0);
    chk("R12 pins", pwmOut, 0);
    chk("R12 irq", irqOut, 0);

    // R2 register map vectors
    for (int i = 0; i < NVEC; i++) begin
      wr(VEC[i].addr, VEC[i].wdat);
      rd(VEC[i].addr, v);
      chk("R2 map", {VEC[i].addr, v}, {VEC[i].addr, VEC[i].expv});
    end
    for (int i = 0; i < NVEC; i++) wr(VEC[i].addr, 16'h0000);

    // R1 start gating
    wr(8'h00, 16'h0001);
    rd(8'h24, v); chk("R1 no tick on start edge", v, 0);
    repeat (10) @(negedge clk);
    rd(8'h24, v); chk("R1 counting", v, 10);
    wr(8'h00, 16'h0000);
    repeat (5) @(negedge clk);
    rd(8'h24, v); chk("R1 held when stopped", v, 11);
    rd(8'h64, v); chk("R1 other channel idle", v, 0);

    // R13 counter load
    wr(8'h24, 16'h1234);
    rd(8'h24, v); chk("R13 load", v, 16'h1234);

    // R5 clear sources
    wr(8'h28, 16'd9); wr(8'h2C, 16'd4); wr(8'h30, 16'd6); wr(8'h34, 16'd2);
    runCount(16'h0020, 0, 13, v); chk("R5 clear A", v, 3);
    runCount(16'h0040, 0, 13, v); chk("R5 clear B", v, 3);
    runCount(16'h00A0, 0, 13, v); chk("R5 clear C", v, 6);
    runCount(16'h00C0, 0, 13, v); chk("R5 clear D", v, 1);
    runCount(16'h0060, 0, 13, v); chk("R5 unused code", v, 13);
    runCount(16'h0000, 16'hFFFE, 3, v); chk("R5 wrap", v, 1);

    // R3 / R4 prescaler and edges over 64 cycles
    runCount(16'h0000, 0, 64, v); chk("R3 div1", v, 64);
    runCount(16'h0001, 0, 64, v); chk("R3 div4 rise", v, 16);
    runCount(16'h0003, 0, 64, v); chk("R3 div64 rise", v, 1);
    runCount(16'h0011, 0, 64, v); chk("R4 div4 both", v, 32);
    runCount(16'h000A, 0, 64, v); chk("R4 div16 fall", v, 4);
    runCount(16'h0013, 0, 64, v); chk("R4 div64 both", v, 2);
    runCount(16'h0010, 0, 64, v); chk("R4 div1 both", v, 64);

    // R6 PWM on ch1: A=2, B=5, start level 1, drive 0 on A
    wr(8'h68, 16'd2); wr(8'h6C, 16'd5); wr(8'h50, 16'h0040);
    wr(8'h54, 16'd2); wr(8'h58, 16'd5); wr(8'h64, 16'd0);
    wr(8'h00, 16'h0002);
    chk("R6 start level", pwmOut[1], 1);
    for (int k = 1; k <= 18; k++) begin
      @(negedge clk);
      rd(8'h64, v);
      chk("R6 period count", v, k % 6);
      chk("R6 pin", pwmOut[1], (v <= 2));
    end

    // R9 duty rewrite while running
    rd(8'h64, c0);
    wr(8'h68, 16'd4);
    rd(8'h64, v); chk("R9 counter undisturbed", v, (c0 + 1) % 6);
    for (int j = 1; j <= 12; j++) begin
      @(negedge clk);
      rd(8'h64, v);
      chk("R9 new duty", {v, 7'd0, pwmOut[1]}, {16'((c0 + 1 + j) % 6), 7'd0, (((c0 + 1 + j) % 6) <= 4)});
    end

    // R8 static levels
    wr(8'h58, 16'd4);
    for (int j = 0; j < 8; j++) begin
      @(negedge clk); chk("R8 held high", pwmOut[1], 1);
    end
    wr(8'h58, 16'd0);
    for (int j = 0; j < 8; j++) begin
      @(negedge clk); chk("R8 held low", pwmOut[1], 0);
    end
    wr(8'h00, 16'h0000);

    // R7 normal mode actions on ch2: A=3, clear on A
    wr(8'hA8, 16'd3); wr(8'h90, 16'h0020); wr(8'h94, 16'd0);
    wr(8'h98, 16'd3); wr(8'hA4, 16'd0);
    wr(8'h00, 16'h0004);
    chk("R7 load start level", pwmOut[2], 0);
    for (int k = 1; k <= 16; k++) begin
      @(negedge clk); chk("R7 toggle", pwmOut[2], (k / 4) % 2);
    end
    wr(8'h98, 16'd2);
    chk("R7 write loads level", pwmOut[2], 0);
    repeat (8) @(negedge clk);
    chk("R7 drive high kept", pwmOut[2], 1);
    wr(8'h98, 16'd5);
    chk("R7 write loads high", pwmOut[2], 1);
    repeat (8) @(negedge clk);
    chk("R7 drive low kept", pwmOut[2], 0);
    wr(8'h00, 16'h0000);

    // R10 / R11 status and interrupt on ch3: A=1 B=3 C=7 D=9, clear on D
    wr(8'hE8, 16'd1); wr(8'hEC, 16'd3); wr(8'hF0, 16'd7); wr(8'hF4, 16'd9);
    wr(8'hD0, 16'h00C0); wr(8'hE4, 16'd0);
    rd(8'hE0, v); chk("R10 initially clear", v, 0);
    wr(8'h00, 16'h0008);
    repeat (3) @(negedge clk);
    wr(8'h00, 16'h0000);
    rd(8'hE0, v); chk("R10 A and B flags", v, 16'h3);
    chk("R11 masked off", irqOut[3], 0);
    wr(8'hDC, 16'h0004); chk("R11 other bit enabled", irqOut[3], 0);
    wr(8'hDC, 16'h0002); chk("R11 enabled flag", irqOut[3], 1);
    wr(8'hE0, 16'hFFFE);
    rd(8'hE0, v); chk("R10 clear bit0 only", v, 16'h2);
    chk("R11 still pending", irqOut[3], 1);
    wr(8'hE0, 16'hFFFD);
    rd(8'hE0, v); chk("R10 clear bit1", v, 0);
    chk("R11 dropped", irqOut[3], 0);
    wr(8'hE0, 16'hFFFF);
    rd(8'hE0, v); chk("R10 ones do not set", v, 0);
    wr(8'hE4, 16'd6);
    wr(8'h00, 16'h0008);
    repeat (2) @(negedge clk);
    wr(8'h00, 16'h0000);
    rd(8'hE0, v); chk("R10 C flag", v, 16'h4);
    wr(8'h00, 16'h0008);
    wr(8'h00, 16'h0000);
    rd(8'hE0, v); chk("R10 D flag", v, 16'hC);
    rd(8'hE4, v); chk("R5 cleared on D", v, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule